// File: doc/BRIEF.md
# SIMT Split-Join Reconvergence Stack

This block tracks which threads of one warp are enabled while the warp runs code that branches in different directions for different threads. When a split instruction issues, the block takes the per-thread predicate and divides the currently enabled threads into two groups. One group has the predicate set and the other has it clear. The block remembers what it needs to run the second group later. It then lets only the first group run. Each join instruction pops one stored record. The first join of a divergent region sends fetch back to a stored resume address, with the deferred group enabled. The second join re-enables every thread that was active before the split, and fetch simply falls through.

If every enabled thread agrees on the predicate, the split stores a single record that carries no address. The matching join then only restores the mask. Regions may nest up to the stack depth. A push that would not fit and a pop from an empty stack are both refused, and each raises a one-cycle flag. Fetch and predicate evaluation sit outside the block.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset, `active_o` is all ones, the stack holds no records, and `redirect_o`, `overflow_o` and `underflow_o` are 0.
- R2: A split whose predicate leaves at least one enabled thread on each side is divergent. From the next cycle, `active_o` equals the previous active mask ANDed with `pred_i`, and there is no redirect.
- R3: A split where all enabled threads share one predicate value leaves `active_o` unchanged and pushes one record.
- R4: The first join after a divergent split pulses `redirect_o` for one cycle on the next cycle. `redirect_pc_o` then equals the `resume_pc_i` given with the split, and `active_o` becomes the enabled threads whose predicate was 0.
- R5: The second join after a divergent split restores the active mask from before the split and does not redirect.
- R6: The join that matches a unanimous split restores the mask from before that split and does not redirect.
- R7: Records are popped last-in first-out, so nested regions unwind innermost first.
- R8: A divergent split needs two free records and a unanimous split needs one. If they are not free, `overflow_o` pulses for one cycle on the next cycle, and both `active_o` and the stack contents are left as they were.
- R9: A join on an empty stack pulses `underflow_o` for one cycle on the next cycle. `active_o` is left unchanged and there is no redirect.
- R10: When `split_i` and `join_i` are high in the same cycle, the split is performed and the join is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| split_i | input | 1 | Split instruction strobe |
| join_i | input | 1 | Join instruction strobe |
| pred_i | input | LANES | Per-thread predicate for the split |
| resume_pc_i | input | PCW | Address where the deferred threads resume |
| active_o | output | LANES | Current active thread mask |
| redirect_o | output | 1 | One-cycle fetch redirect request |
| redirect_pc_o | output | PCW | Redirect target, valid with `redirect_o` |
| overflow_o | output | 1 | One-cycle flag: split refused, stack too full |
| underflow_o | output | 1 | One-cycle flag: join refused, stack empty |

## Verification
A wrong record count or a wrong top-of-stack index shows up at the very next join. Depending on the fault, that join restores the wrong mask, redirects when it should fall through, or raises underflow one pop too early or too late. The bench therefore drains every scenario until underflow. A corrupted stored mask or address is visible on `active_o` or `redirect_pc_o` in the cycle after the join that pops it. A fault in splitting the mask shows on `active_o` in the cycle after the split.

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack #(
  parameter int LANES = 4,
  parameter int DEPTH = 8,
  parameter int PCW   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             split_i,
  input  logic             join_i,
  input  logic [LANES-1:0] pred_i,
  input  logic [PCW-1:0]   resume_pc_i,
  output logic [LANES-1:0] active_o,
  output logic             redirect_o,
  output logic [PCW-1:0]   redirect_pc_o,
  output logic             overflow_o,
  output logic             underflow_o
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [LANES-1:0] mask_q [DEPTH];
  logic [PCW-1:0]   pc_q   [DEPTH];
  logic [DEPTH-1:0] haspc_q;
  logic [CW-1:0]    cnt_q;

  logic [LANES-1:0] taken, fallen;
  logic             diverge, do_split, do_join, split_ok, empty;
  logic [IW-1:0]    lo_idx, hi_idx, top_idx;

  assign taken    = active_o & pred_i;
  assign fallen   = active_o & ~pred_i;
  assign diverge  = (|taken) && (|fallen);
  assign do_split = split_i;
  assign do_join  = join_i && !split_i;
  assign empty    = (cnt_q == '0);
  assign split_ok = diverge ? (cnt_q <= FULL - CW'(2)) : (cnt_q != FULL);
  assign lo_idx   = IW'(cnt_q);
  assign hi_idx   = IW'(cnt_q + CW'(1));
  assign top_idx  = IW'(cnt_q - CW'(1));

  always_ff @(posedge clk) begin
    if (do_split && split_ok) begin
      mask_q[lo_idx]  <= active_o;
      pc_q[lo_idx]    <= '0;
      haspc_q[lo_idx] <= 1'b0;
      if (diverge) begin
        mask_q[hi_idx]  <= fallen;
        pc_q[hi_idx]    <= resume_pc_i;
        haspc_q[hi_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q         <= '0;
      active_o      <= '1;
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
      overflow_o    <= 1'b0;
      underflow_o   <= 1'b0;
    end else begin
      redirect_o  <= 1'b0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
      if (do_split) begin
        if (!split_ok) begin
          overflow_o <= 1'b1;
        end else if (diverge) begin
          cnt_q    <= cnt_q + CW'(2);
          active_o <= taken;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else if (do_join) begin
        if (empty) begin
          underflow_o <= 1'b1;
        end else begin
          cnt_q    <= cnt_q - CW'(1);
          active_o <= mask_q[top_idx];
          if (haspc_q[top_idx]) begin
            redirect_o    <= 1'b1;
            redirect_pc_o <= pc_q[top_idx];
          end
        end
      end
    end
  end

endmodule

// File: rtl/simt_reconv_stack_chk.sv
module simt_reconv_stack_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             split_i,
  input logic             join_i,
  input logic [LANES-1:0] active_o,
  input logic             redirect_o,
  input logic             overflow_o,
  input logic             underflow_o
);

  a_r2_split_narrows: assert property (@(posedge clk) disable iff (!rst_n)
    split_i |=> ((active_o & ~$past(active_o)) == '0));

  a_r8_overflow_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> $stable(active_o));

  a_r9_underflow_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> ($stable(active_o) && !redirect_o));

  a_r4_redirect_single: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> !redirect_o);

  a_r10_split_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (split_i && join_i) |=> (!underflow_o && !redirect_o));

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({redirect_o, overflow_o, underflow_o}) <= 1);

endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .split_i(split_i), .join_i(join_i),
  .active_o(active_o), .redirect_o(redirect_o),
  .overflow_o(overflow_o), .underflow_o(underflow_o)
);

// File: tb/simt_reconv_stack_tb.sv
`timescale 1ns/1ps
module simt_reconv_stack_tb;
  localparam int L = 4;
  localparam int D = 8;
  localparam int P = 16;
  localparam logic [L-1:0] ALL = '1;

  logic clk = 1'b0, rst_n = 1'b0, split_i = 1'b0, join_i = 1'b0;
  logic [L-1:0] pred_i = '0;
  logic [P-1:0] resume_pc_i = '0;
  logic [L-1:0] active_o;
  logic redirect_o, overflow_o, underflow_o;
  logic [P-1:0] redirect_pc_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  simt_reconv_stack #(.LANES(L), .DEPTH(D), .PCW(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .split_i(split_i), .join_i(join_i),
    .pred_i(pred_i), .resume_pc_i(resume_pc_i), .active_o(active_o),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .overflow_o(overflow_o), .underflow_o(underflow_o));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(bit s, bit j, logic [L-1:0] p, logic [P-1:0] pc);
    @(negedge clk);
    split_i = s; join_i = j; pred_i = p; resume_pc_i = pc;
    @(negedge clk);
    split_i = 0; join_i = 0; pred_i = '0; resume_pc_i = '0;
  endtask

  task automatic expect_join(string req, bit red, logic [P-1:0] pc, logic [L-1:0] m);
    op(0, 1, '0, '0);
    chk(req, {active_o, redirect_o, overflow_o, underflow_o},
        {m, red, 1'b0, 1'b0});
    if (red) chk(req, redirect_pc_o, pc);
  endtask

  task automatic expect_underflow(string req, logic [L-1:0] m);
    op(0, 1, '0, '0);
    chk(req, {active_o, redirect_o, overflow_o, underflow_o},
        {m, 1'b0, 1'b0, 1'b1});
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {active_o, redirect_o, overflow_o, underflow_o}, {ALL, 3'b000});
    expect_underflow("R1 R9", ALL);

    // Single-level sweep over all predicates (R2 R3 R4 R5 R6)
    for (int p = 0; p < 16; p++) begin
      logic [L-1:0] t, f;
      t = L'(p) & ALL; f = ~L'(p) & ALL;
      op(1, 0, L'(p), P'(16'h100 + p));
      if (t != 0 && f != 0) begin
        chk("R2", {active_o, redirect_o}, {t, 1'b0});
        expect_join("R4", 1, P'(16'h100 + p), f);
        expect_join("R5", 0, '0, ALL);
      end else begin
        chk("R3", {active_o, redirect_o}, {ALL, 1'b0});
        expect_join("R6", 0, '0, ALL);
      end
      expect_underflow("R9", ALL);
    end

    // Nested sweep (R7)
    for (int p1 = 0; p1 < 16; p1++) begin
      for (int p2 = 0; p2 < 16; p2++) begin
        logic [L-1:0] t1, f1, a1, t2, f2;
        bit d1, d2;
        t1 = L'(p1); f1 = ~L'(p1);
        d1 = (t1 != 0) && (f1 != 0);
        a1 = d1 ? t1 : ALL;
        t2 = a1 & L'(p2); f2 = a1 & ~L'(p2);
        d2 = (t2 != 0) && (f2 != 0);
        op(1, 0, L'(p1), 16'hA000);
        op(1, 0, L'(p2), 16'hB000);
        chk("R7 inner split", active_o, d2 ? t2 : a1);
        if (d2) expect_join("R7 inner redirect", 1, 16'hB000, f2);
        expect_join("R7 inner restore", 0, '0, a1);
        if (d1) expect_join("R7 outer redirect", 1, 16'hA000, f1);
        expect_join("R7 outer restore", 0, '0, ALL);
        expect_underflow("R7 drained", ALL);
      end
    end

    // Overflow (R8): fill with unanimous splits
    for (int i = 0; i < D - 1; i++) op(1, 0, 4'hF, '0);
    op(1, 0, 4'h3, 16'hC000);
    chk("R8 divergent no room", {active_o, overflow_o}, {ALL, 1'b1});
    op(1, 0, 4'hF, '0);
    chk("R8 last slot", {active_o, overflow_o}, {ALL, 1'b0});
    op(1, 0, 4'h0, '0);
    chk("R8 full", {active_o, overflow_o}, {ALL, 1'b1});
    for (int i = 0; i < D; i++) expect_join("R8 contents kept", 0, '0, ALL);
    expect_underflow("R8 count kept", ALL);

    // Simultaneous split and join (R10)
    op(1, 1, 4'h3, 16'hD000);
    chk("R10", {active_o, redirect_o, underflow_o}, {4'h3, 1'b0, 1'b0});
    expect_join("R10 deferred", 1, 16'hD000, 4'hC);
    expect_join("R10 restore", 0, '0, ALL);
    expect_underflow("R10 drained", ALL);

    finish_up();
  end
endmodule